// File: doc/BRIEF.md
# Sign-Power-of-Two LMS Weight Increment

This block keeps the four coefficients of a four-tap adaptive filter and applies the least-mean-square update to them. It does not multiply the error by a step size. It reads the position of the highest set bit in the error's magnitude and turns that position into a right-shift amount. Each tap's input sample is shifted arithmetically by that amount. The sign of the error then decides whether the shifted sample is added to the weight or subtracted from it. The result saturates to the 8-bit signed range.

An update is applied when the update strobe is high at a clock edge. In the same edge, the new weights are loaded into a serializer. The serializer sends each weight on its own wire, one bit per cycle, so that a bit-serial inner-product unit can use them. A frame-valid flag is high for the whole frame.

Top module: `spt_weight_update`

## Requirements
- R1: After reset, every weight is 0 and `ser_valid_o` is low.
- R2: The error is read as a sign bit `err_i[7]` plus a 7-bit magnitude `err_i[6:0]`. When `upd_valid_i` is high and the magnitude is nonzero, each weight changes at that edge. With sign 0 the weight becomes w + inc; with sign 1 it becomes w - inc.
- R3: The shift amount is (6 - p) + SHIFT_OFS, where p is the index of the highest set bit of `err_i[6:0]` and SHIFT_OFS defaults to 1. For example, bit 6 set gives 1, and only bit 0 set gives 7.
- R4: The increment is the tap's sample `x_i[8k+7:8k]`, taken as signed and shifted arithmetically right. The sign is kept, so a negative sample never yields a positive increment.
- R5: An update whose magnitude is zero (`err_i` equal to 0x00 or 0x80) leaves every weight unchanged.
- R6: A sum above 127 gives 127, and a sum below -128 gives -128.
- R7: When `upd_valid_i` is low, the weights hold their values.
- R8: Starting in the cycle after an update edge, `ser_bit_o[k]` presents bit j of the new weight k in the j-th cycle (j = 0..7), least significant bit first.
- R9: `ser_valid_o` rises in the cycle after an update edge and stays high for exactly 8 cycles. A new update during a frame restarts the frame with the new weights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_valid_i | input | 1 | Apply an update at this edge |
| err_i | input | 8 | Error: bit 7 is the sign, bits 6:0 are the magnitude |
| x_i | input | 32 | Four signed 8-bit samples, tap k in bits 8k+7:8k |
| wt_o | output | 32 | Four signed 8-bit weights, tap k in bits 8k+7:8k |
| ser_bit_o | output | 4 | Serial weight bits, one per tap, LSB first |
| ser_valid_o | output | 1 | High during an 8-cycle serial frame |

## Verification
The error inputs include a single magnitude bit at every position, so each shift amount from 1 to 7 is used. They also include both zero-magnitude codes, to show that the sign alone never causes an update. Samples of both signs, including -1 and -128, separate an arithmetic shift from a logical one. Repeated updates in one direction with full-scale samples drive the weights to both saturation limits. Long random runs then mix idle gaps with update strobes that arrive in the middle of a frame. These runs show that a frame restarts and that the serial bits always follow the newest weights.

// File: rtl/spt_pkg.sv
package spt_pkg;
  // width of a shift amount covering (err_w-2)+ofs
  function automatic int sh_width(input int err_w, input int ofs);
    return $clog2(err_w - 2 + ofs + 1);
  endfunction
endpackage

// File: rtl/spt_lead_decode.sv
module spt_lead_decode #(
  parameter int ERR_W     = 8,
  parameter int SHIFT_OFS = 1,
  parameter int SH_W      = 3
) (
  input  logic [ERR_W-2:0] mag_i,
  output logic [SH_W-1:0]  shamt_o,
  output logic             zero_o
);
  always_comb begin
    zero_o  = (mag_i == '0);
    shamt_o = '0;
    // ascending scan: the highest set bit wins
    for (int i = 0; i < ERR_W - 1; i++) begin
      if (mag_i[i]) shamt_o = SH_W'(ERR_W - 2 - i + SHIFT_OFS);
    end
  end
endmodule

// File: rtl/spt_tap_update.sv
module spt_tap_update #(
  parameter int W    = 8,
  parameter int SH_W = 3
) (
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] w_i,
  input  logic [SH_W-1:0]     shamt_i,
  input  logic                dec_i,
  input  logic                en_i,
  output logic signed [W-1:0] w_o
);
  localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] inc;
  logic signed [W:0]   sum;
  logic                ovf;

  always_comb begin
    inc = x_i >>> shamt_i;
    sum = dec_i ? ({w_i[W-1], w_i} - {inc[W-1], inc})
                : ({w_i[W-1], w_i} + {inc[W-1], inc});
    ovf = sum[W] ^ sum[W-1];
    if (!en_i)    w_o = w_i;
    else if (ovf) w_o = sum[W] ? MIN_V : MAX_V;
    else          w_o = sum[W-1:0];
  end
endmodule

// File: rtl/spt_serializer.sv
module spt_serializer #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [N*W-1:0] par_i,
  output logic [N-1:0]   bit_o,
  output logic           valid_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     sr_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CNT_W'(W);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            sr_q[k] <= '0;
      else if (load_i)        sr_q[k] <= par_i[k*W +: W];
      else if (cnt_q != '0)   sr_q[k] <= sr_q[k] >> 1;
    end
    assign bit_o[k] = sr_q[k][0];
  end

  assign valid_o = (cnt_q != '0);
endmodule

// File: rtl/spt_weight_update.sv
module spt_weight_update #(
  parameter int N_TAPS    = 4,
  parameter int W         = 8,
  parameter int ERR_W     = 8,
  parameter int SHIFT_OFS = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                upd_valid_i,
  input  logic [ERR_W-1:0]    err_i,
  input  logic [N_TAPS*W-1:0] x_i,
  output logic [N_TAPS*W-1:0] wt_o,
  output logic [N_TAPS-1:0]   ser_bit_o,
  output logic                ser_valid_o
);
  localparam int SH_W = spt_pkg::sh_width(ERR_W, SHIFT_OFS);

  logic [SH_W-1:0]     shamt;
  logic                mag_zero;
  logic [N_TAPS*W-1:0] w_q, w_nxt;

  spt_lead_decode #(.ERR_W(ERR_W), .SHIFT_OFS(SHIFT_OFS), .SH_W(SH_W)) u_dec (
    .mag_i  (err_i[ERR_W-2:0]),
    .shamt_o(shamt),
    .zero_o (mag_zero)
  );

  for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
    spt_tap_update #(.W(W), .SH_W(SH_W)) u_tap (
      .x_i    (x_i[k*W +: W]),
      .w_i    (w_q[k*W +: W]),
      .shamt_i(shamt),
      .dec_i  (err_i[ERR_W-1]),
      .en_i   (!mag_zero),
      .w_o    (w_nxt[k*W +: W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          w_q <= '0;
    else if (upd_valid_i) w_q <= w_nxt;
  end

  spt_serializer #(.N(N_TAPS), .W(W)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (upd_valid_i),
    .par_i  (w_nxt),
    .bit_o  (ser_bit_o),
    .valid_o(ser_valid_o)
  );

  assign wt_o = w_q;
endmodule

// File: rtl/spt_weight_update_chk.sv
module spt_weight_update_chk #(
  parameter int N_TAPS = 4,
  parameter int W      = 8,
  parameter int ERR_W  = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                upd_valid_i,
  input logic [ERR_W-1:0]    err_i,
  input logic [N_TAPS*W-1:0] x_i,
  input logic [N_TAPS*W-1:0] wt_o,
  input logic [N_TAPS-1:0]   ser_bit_o,
  input logic                ser_valid_o
);
  logic [N_TAPS-1:0] w_lsb;
  always_comb
    for (int k = 0; k < N_TAPS; k++) w_lsb[k] = wt_o[k*W];

  p_hold_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(wt_o));

  p_zero_mag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && err_i[ERR_W-2:0] == '0) |=> $stable(wt_o));

  p_frame_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> ser_valid_o);

  p_first_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> (ser_bit_o == w_lsb));

  for (genvar k = 0; k < N_TAPS; k++) begin : g_dir
    p_sign_dir_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_valid_i && err_i[ERR_W-2:0] != '0 && !err_i[ERR_W-1] && !x_i[k*W+W-1])
      |=> ($signed(wt_o[k*W +: W]) >= $signed($past(wt_o[k*W +: W]))));
  end

  always_comb
    if (rst_ni) p_valid_flag_known_r9: assert (!$isunknown(ser_valid_o));
endmodule

bind spt_weight_update spt_weight_update_chk #(
  .N_TAPS(N_TAPS), .W(W), .ERR_W(ERR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .upd_valid_i(upd_valid_i),
  .err_i      (err_i),
  .x_i        (x_i),
  .wt_o       (wt_o),
  .ser_bit_o  (ser_bit_o),
  .ser_valid_o(ser_valid_o)
);

// File: tb/spt_weight_update_test.sv
`timescale 1ns/1ps
module spt_weight_update_test;
  localparam int OFS = 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        upd_valid_i = 1'b0;
  logic [7:0]  err_i = '0;
  logic [31:0] x_i = '0;
  logic [31:0] wt_o;
  logic [3:0]  ser_bit_o;
  logic        ser_valid_o;

  int compared = 0;
  int mismatched = 0;
  int mw[4];
  int msr[4];
  int mcnt = 0;
  string tag = "R1";

  always #2 clk_i = ~clk_i;

  spt_weight_update #(.SHIFT_OFS(OFS)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_valid_i(upd_valid_i), .err_i(err_i),
    .x_i(x_i), .wt_o(wt_o), .ser_bit_o(ser_bit_o), .ser_valid_o(ser_valid_o)
  );

  function automatic int sat8(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference, evaluated just after the edge
  task automatic model_step();
    int p, s, inc, v;
    bit any_sat;
    if (upd_valid_i) begin
      p = -1;
      for (int i = 6; i >= 0; i--) if (p < 0 && err_i[i]) p = i;
      any_sat = 1'b0;
      if (p < 0) tag = "R5";
      else begin
        s = 6 - p + OFS;  // R3 decode
        for (int k = 0; k < 4; k++) begin
          inc = int'($signed(x_i[k*8 +: 8])) >>> s;  // R4 arithmetic
          v = err_i[7] ? mw[k] - inc : mw[k] + inc;
          if (v != sat8(v)) any_sat = 1'b1;
          mw[k] = sat8(v);
        end
        tag = any_sat ? "R6" : "R2,R3,R4";
      end
      for (int k = 0; k < 4; k++) msr[k] = mw[k] & 255;
      mcnt = 8;
    end else begin
      tag = "R7";
      if (mcnt > 0) begin
        mcnt--;
        for (int k = 0; k < 4; k++) msr[k] = msr[k] >> 1;
      end
    end
  endtask

  task automatic compare_all();
    int a;
    for (int k = 0; k < 4; k++) begin
      a = int'($signed(wt_o[k*8 +: 8]));
      check(a == mw[k], tag, $sformatf("tap%0d weight", k), a, mw[k]);
    end
    check(ser_valid_o == (mcnt > 0), "R9", "ser_valid_o", int'(ser_valid_o), int'(mcnt > 0));
    if (mcnt > 0)
      for (int k = 0; k < 4; k++)
        check(ser_bit_o[k] == msr[k][0], "R8", $sformatf("tap%0d serial bit", k),
              int'(ser_bit_o[k]), msr[k] & 1);
  endtask

  task automatic cyc(input bit u, input logic [7:0] e, input logic [31:0] x);
    upd_valid_i = u;
    err_i = e;
    x_i = x;
    @(posedge clk_i);
    #0.5 model_step();
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int k = 0; k < 4; k++) begin mw[k] = 0; msr[k] = 0; end
    repeat (3) @(negedge clk_i);
    for (int k = 0; k < 4; k++)
      check(wt_o[k*8 +: 8] == 8'd0, "R1", "reset weight", int'(wt_o[k*8 +: 8]), 0);
    check(!ser_valid_o, "R1", "reset valid", int'(ser_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // every magnitude bit position, both signs, mixed-sign samples
    for (int b = 6; b >= 0; b--) begin
      cyc(1'b1, 8'(1 << b), {8'h80, 8'hFF, 8'h07, 8'h64});
      cyc(1'b0, 8'h00, '0);
      cyc(1'b1, 8'h80 | 8'(1 << b) | 8'(1 << (b > 0 ? b - 1 : 0)), {8'h7F, 8'h9C, 8'h01, 8'hC0});
    end
    // zero magnitude, both signs: no change
    cyc(1'b1, 8'h00, 32'h7F7F7F7F);
    cyc(1'b1, 8'h80, 32'h80808080);
    repeat (9) cyc(1'b0, 8'h55, 32'h12345678);
    // drive to the positive and negative limits
    repeat (6) cyc(1'b1, 8'h7F, {8'h7F, 8'h80, 8'h7F, 8'h80});
    repeat (10) cyc(1'b1, 8'hFF, {8'h7F, 8'h80, 8'h7F, 8'h80});
    // restart a frame mid-way
    cyc(1'b1, 8'h20, 32'h40C0_20E0);
    repeat (3) cyc(1'b0, 8'h00, '0);
    cyc(1'b1, 8'hA0, 32'h11223344);
    repeat (10) cyc(1'b0, 8'h00, '0);
    for (int i = 0; i < 600; i++)
      cyc($urandom_range(0, 3) == 0, 8'($urandom), $urandom);
    summary();
  end
endmodule